// File: doc/BRIEF.md
# Multi-buffer capture write address generator

This block produces the external-memory write addresses for image frames captured from a sensor. It serves one of four frame buffers at a time. Each buffer has a start address and a terminating address pattern. Inside a frame the block moves through the buffer in columns and rows, using a programmable column stride and a separate row stride. It performs a programmable number of column steps in each row before it moves to the next row. Every address goes out with a valid/ready handshake. When the address equal to the buffer's end pattern is accepted, the frame is complete and the writer goes idle.

Software drives the block through a small write-only register port. The registers hold the buffer bases and end patterns, the strides, the burst count and a control word. The control word carries the buffer-enable and writer-enable masks and the strobe byte. It also carries the one-shot load, restart and switch requests and the level-sensitive rotation freeze. Rotation visits the enabled buffers in ascending order and wraps at the top. Status outputs report the selected buffer, a per-writer inactive flag, the strobe byte and a pulse that marks each completed frame.

Top module: `capwr_addr_gen`

## Requirements
- R1: After reset, `addr_valid_o` is 0, `buf_sel_o` is 0, `writer_inactive_o` is all ones and `strb_o` is 0xFC. Buffer k starts at 0x18000000 + k*0x02000000 and its end pattern is that base + 0x01FF0000. Both strides are 0x80 and the burst count is 0x7E.
- R2: Register indices on `cfg_sel_i`: 0-3 hold the buffer bases, 4-7 the end patterns, 8 the column stride, 9 the row stride, 10 the burst count and 11 the control word. The control word fields are: [3:0] buffer enable, [7:4] writer enable, [15:8] strobe, [16] switch, [17] load, [18] restart, [19] freeze. A control write with load set causes `addr_o` to show the selected buffer's base with `addr_valid_o` high after that same clock edge.
- R3: Each accepted address moves to the next address in the current row by adding the column stride. After the burst count's worth of column steps, the next address is the row start plus the row stride.
- R4: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_o` and `addr_valid_o` hold.
- R5: When the accepted address equals the selected buffer's end pattern, `frame_done_o` pulses in that cycle. `addr_valid_o` is then low until the next load or switch.
- R6: A switch request is held pending. It is applied one cycle after the request if the writer is idle, or otherwise at the end of the current frame. Applying it selects the next enabled buffer above the current one, wrapping past the top, and starts a frame at that buffer's base.
- R7: When no buffer is enabled, an applied switch keeps `buf_sel_o` unchanged and restarts the frame at the same base.
- R8: While the freeze bit is set, a pending switch is not applied. It takes effect once the freeze is cleared.
- R9: A restart request reloads the selected buffer's base and clears the row progress. It leaves the running or idle state unchanged.
- R10: `addr_valid_o` requires the writer-enable bit of the selected buffer. `writer_inactive_o[k]` is 0 only for the selected buffer while an address is being offered.
- R11: `strb_o` equals the strobe field of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | SELW (4) | Register index |
| cfg_wdata_i | input | AW (32) | Register write data |
| addr_o | output | AW (32) | Current write address |
| addr_valid_o | output | 1 | Address offered |
| addr_ready_i | input | 1 | Downstream accepts the address |
| strb_o | output | STBW (8) | Write strobe byte |
| buf_sel_o | output | BW (2) | Selected buffer |
| writer_inactive_o | output | NBUF (4) | Per-writer inactive flags |
| frame_done_o | output | 1 | Last address of a frame accepted |

## Verification
The bench builds the block with its defaults: four buffers, 32-bit addresses, a 12-bit burst count and an 8-bit strobe. With these settings the reset values themselves can be checked, including a 130-address walk that crosses the default 127-address row. Short frames are then programmed: stride 4, row stride 0x100, burst count 2 and end patterns two rows in. These make a whole frame only eight addresses long. That brings frame completion, chained switching that skips a disabled buffer, wrap-around, freeze, restart and writer gating into a few hundred cycles, under random back-pressure.

// File: rtl/capwr_pkg.sv
package capwr_pkg;
  // one-shot requests decoded from a control write
  typedef struct packed {
    logic sw;
    logic ld;
    logic rs;
  } capwr_req_t;
endpackage

// File: rtl/capwr_cfg.sv
module capwr_cfg #(
  parameter int unsigned NBUF = 4,
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 12,
  parameter int unsigned STBW = 8,
  parameter int unsigned SELW = 4,
  parameter logic [AW-1:0] DEF_BASE    = 'h1800_0000,
  parameter logic [AW-1:0] BUF_STRIDE  = 'h0200_0000,
  parameter logic [AW-1:0] END_OFS     = 'h01FF_0000,
  parameter logic [AW-1:0] DEF_COL_INC = 'h80,
  parameter logic [AW-1:0] DEF_ROW_INC = 'h80,
  parameter logic [CW-1:0] DEF_BURST   = 'h7E,
  parameter logic [STBW-1:0] DEF_STRB  = 'hFC
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [SELW-1:0]           sel_i,
  input  logic [AW-1:0]             wdata_i,
  output logic [NBUF-1:0][AW-1:0]   base_o,
  output logic [NBUF-1:0][AW-1:0]   end_o,
  output logic [AW-1:0]             col_inc_o,
  output logic [AW-1:0]             row_inc_o,
  output logic [CW-1:0]             burst_o,
  output logic [NBUF-1:0]           buf_en_o,
  output logic [NBUF-1:0]           wr_en_o,
  output logic [STBW-1:0]           strb_o,
  output logic                      block_o,
  output capwr_pkg::capwr_req_t     req_o
);
  localparam int unsigned SEL_END   = NBUF;
  localparam int unsigned SEL_COL   = 2 * NBUF;
  localparam int unsigned SEL_ROW   = SEL_COL + 1;
  localparam int unsigned SEL_BURST = SEL_COL + 2;
  localparam int unsigned SEL_CTRL  = SEL_COL + 3;
  localparam int unsigned WEN_LSB   = NBUF;
  localparam int unsigned STB_LSB   = 2 * NBUF;
  localparam int unsigned SW_BIT    = STB_LSB + STBW;
  localparam int unsigned LD_BIT    = SW_BIT + 1;
  localparam int unsigned RS_BIT    = SW_BIT + 2;
  localparam int unsigned BLK_BIT   = SW_BIT + 3;

  logic ctrl_wr;
  assign ctrl_wr = we_i && (sel_i == SELW'(SEL_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBUF; i++) begin
        base_o[i] <= DEF_BASE + AW'(i) * BUF_STRIDE;
        end_o[i]  <= DEF_BASE + AW'(i) * BUF_STRIDE + END_OFS;
      end
      col_inc_o <= DEF_COL_INC;
      row_inc_o <= DEF_ROW_INC;
      burst_o   <= DEF_BURST;
      buf_en_o  <= '1;
      wr_en_o   <= '1;
      strb_o    <= DEF_STRB;
      block_o   <= 1'b0;
    end else if (we_i) begin
      for (int i = 0; i < NBUF; i++) begin
        if (sel_i == SELW'(i))           base_o[i] <= wdata_i;
        if (sel_i == SELW'(SEL_END + i)) end_o[i]  <= wdata_i;
      end
      if (sel_i == SELW'(SEL_COL))   col_inc_o <= wdata_i;
      if (sel_i == SELW'(SEL_ROW))   row_inc_o <= wdata_i;
      if (sel_i == SELW'(SEL_BURST)) burst_o   <= wdata_i[CW-1:0];
      if (ctrl_wr) begin
        buf_en_o <= wdata_i[NBUF-1:0];
        wr_en_o  <= wdata_i[WEN_LSB +: NBUF];
        strb_o   <= wdata_i[STB_LSB +: STBW];
        block_o  <= wdata_i[BLK_BIT];
      end
    end
  end

  always_comb begin
    req_o.sw = ctrl_wr & wdata_i[SW_BIT];
    req_o.ld = ctrl_wr & wdata_i[LD_BIT];
    req_o.rs = ctrl_wr & wdata_i[RS_BIT];
  end
endmodule

// File: rtl/capwr_sel.sv
module capwr_sel #(
  parameter int unsigned NBUF = 4,
  parameter int unsigned BW   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBUF-1:0] buf_en_i,
  input  logic            sw_req_i,
  input  logic            block_i,
  input  logic            window_i,
  input  logic            hold_i,
  output logic [BW-1:0]   sel_o,
  output logic [BW-1:0]   next_o,
  output logic            apply_o
);
  logic [BW-1:0] sel_q;
  logic          pend_q;

  assign sel_o   = sel_q;
  assign apply_o = pend_q & ~block_i & window_i & ~hold_i;

  // nearest enabled buffer above the current one, wrapping; self last
  always_comb begin
    next_o = sel_q;
    for (int k = NBUF; k >= 1; k--) begin
      if (buf_en_i[BW'((int'(sel_q) + k) % NBUF)])
        next_o = BW'((int'(sel_q) + k) % NBUF);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= sw_req_i | (pend_q & ~apply_o);
      if (apply_o) sel_q <= next_o;
    end
  end
endmodule

// File: rtl/capwr_walk.sv
module capwr_walk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_cur_i,
  input  logic [AW-1:0] base_next_i,
  input  logic [AW-1:0] end_cur_i,
  input  logic [AW-1:0] col_inc_i,
  input  logic [AW-1:0] row_inc_i,
  input  logic [CW-1:0] burst_i,
  input  logic          wr_en_i,
  input  logic          ld_i,
  input  logic          rs_i,
  input  logic          apply_i,
  input  logic          ready_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          last_o,
  output logic          window_o
);
  logic [AW-1:0] cur_q, row_q, row_nx;
  logic [CW-1:0] col_q;
  logic          run_q, acc;

  assign addr_o   = cur_q;
  assign valid_o  = run_q & wr_en_i;
  assign acc      = valid_o & ready_i;
  assign last_o   = acc && (cur_q == end_cur_i);
  assign window_o = ~run_q | last_o;
  assign row_nx   = row_q + row_inc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      row_q <= '0;
      col_q <= '0;
      run_q <= 1'b0;
    end else if (ld_i || rs_i) begin
      cur_q <= base_cur_i;
      row_q <= base_cur_i;
      col_q <= '0;
      if (ld_i) run_q <= 1'b1;
    end else if (apply_i) begin
      cur_q <= base_next_i;
      row_q <= base_next_i;
      col_q <= '0;
      run_q <= 1'b1;
    end else if (last_o) begin
      run_q <= 1'b0;
    end else if (acc) begin
      if (col_q == burst_i) begin
        col_q <= '0;
        row_q <= row_nx;
        cur_q <= row_nx;
      end else begin
        col_q <= col_q + 1'b1;
        cur_q <= cur_q + col_inc_i;
      end
    end
  end
endmodule

// File: rtl/capwr_addr_gen.sv
module capwr_addr_gen #(
  parameter int unsigned NBUF = 4,
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 12,
  parameter int unsigned STBW = 8,
  parameter logic [AW-1:0] DEF_BASE    = 'h1800_0000,
  parameter logic [AW-1:0] BUF_STRIDE  = 'h0200_0000,
  parameter logic [AW-1:0] END_OFS     = 'h01FF_0000,
  parameter logic [AW-1:0] DEF_COL_INC = 'h80,
  parameter logic [AW-1:0] DEF_ROW_INC = 'h80,
  parameter logic [CW-1:0] DEF_BURST   = 'h7E,
  parameter logic [STBW-1:0] DEF_STRB  = 'hFC,
  localparam int unsigned BW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int unsigned SELW = $clog2(2 * NBUF + 4)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [SELW-1:0] cfg_sel_i,
  input  logic [AW-1:0]   cfg_wdata_i,
  output logic [AW-1:0]   addr_o,
  output logic            addr_valid_o,
  input  logic            addr_ready_i,
  output logic [STBW-1:0] strb_o,
  output logic [BW-1:0]   buf_sel_o,
  output logic [NBUF-1:0] writer_inactive_o,
  output logic            frame_done_o
);
  logic [NBUF-1:0][AW-1:0] base, endp;
  logic [AW-1:0]           col_inc, row_inc;
  logic [CW-1:0]           burst;
  logic [NBUF-1:0]         buf_en, wr_en;
  logic                    block, window, apply;
  logic [BW-1:0]           next_sel;
  capwr_pkg::capwr_req_t   req;

  capwr_cfg #(
    .NBUF(NBUF), .AW(AW), .CW(CW), .STBW(STBW), .SELW(SELW),
    .DEF_BASE(DEF_BASE), .BUF_STRIDE(BUF_STRIDE), .END_OFS(END_OFS),
    .DEF_COL_INC(DEF_COL_INC), .DEF_ROW_INC(DEF_ROW_INC),
    .DEF_BURST(DEF_BURST), .DEF_STRB(DEF_STRB)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .base_o(base), .end_o(endp), .col_inc_o(col_inc),
    .row_inc_o(row_inc), .burst_o(burst), .buf_en_o(buf_en), .wr_en_o(wr_en),
    .strb_o(strb_o), .block_o(block), .req_o(req)
  );

  capwr_sel #(.NBUF(NBUF), .BW(BW)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .buf_en_i(buf_en), .sw_req_i(req.sw),
    .block_i(block), .window_i(window), .hold_i(req.ld | req.rs),
    .sel_o(buf_sel_o), .next_o(next_sel), .apply_o(apply)
  );

  capwr_walk #(.AW(AW), .CW(CW)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_cur_i(base[buf_sel_o]),
    .base_next_i(base[next_sel]), .end_cur_i(endp[buf_sel_o]),
    .col_inc_i(col_inc), .row_inc_i(row_inc), .burst_i(burst),
    .wr_en_i(wr_en[buf_sel_o]), .ld_i(req.ld), .rs_i(req.rs), .apply_i(apply),
    .ready_i(addr_ready_i), .addr_o(addr_o), .valid_o(addr_valid_o),
    .last_o(frame_done_o), .window_o(window)
  );

  for (genvar i = 0; i < NBUF; i++) begin : g_inact
    assign writer_inactive_o[i] = ~(addr_valid_o && (buf_sel_o == BW'(i)));
  end
endmodule

// File: rtl/capwr_addr_gen_chk.sv
module capwr_addr_gen_chk #(
  parameter int unsigned NBUF = 4,
  parameter int unsigned AW   = 32,
  parameter int unsigned STBW = 8,
  parameter int unsigned BW   = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic [AW-1:0]   addr_o,
  input logic            addr_valid_o,
  input logic            addr_ready_i,
  input logic [STBW-1:0] strb_o,
  input logic [BW-1:0]   buf_sel_o,
  input logic [NBUF-1:0] writer_inactive_o,
  input logic            frame_done_o
);
  a_r4_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i && !cfg_we_i) |=> (addr_valid_o && $stable(addr_o)));

  a_r5_done_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (addr_valid_o && addr_ready_i));

  a_r6_sel_moves_at_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(buf_sel_o) |-> $past(!addr_valid_o || frame_done_o));

  a_r10_one_writer_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> ($countones(writer_inactive_o) == NBUF - 1));

  a_r10_idle_all_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_o |-> (&writer_inactive_o));

  a_r11_strb_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(strb_o));
endmodule

bind capwr_addr_gen capwr_addr_gen_chk #(
  .NBUF(NBUF), .AW(AW), .STBW(STBW), .BW(BW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .addr_o(addr_o),
  .addr_valid_o(addr_valid_o), .addr_ready_i(addr_ready_i), .strb_o(strb_o),
  .buf_sel_o(buf_sel_o), .writer_inactive_o(writer_inactive_o),
  .frame_done_o(frame_done_o)
);

// File: tb/sim_capwr_addr_gen.sv
module sim_capwr_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NBUF = 4;
  localparam int AW   = 32;
  localparam int CW   = 12;
  localparam int STBW = 8;
  localparam int BW   = 2;
  localparam int SELW = $clog2(2 * NBUF + 4);
  localparam int S_CTRL = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [SELW-1:0] sel = '0;
  logic [AW-1:0]   wdata = '0;
  logic            ready = 1'b0;
  logic [AW-1:0]   addr;
  logic            valid, fdone;
  logic [STBW-1:0] strb;
  logic [BW-1:0]   bsel;
  logic [NBUF-1:0] inact;

  capwr_addr_gen #(.NBUF(NBUF), .AW(AW), .CW(CW), .STBW(STBW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .addr_o(addr), .addr_valid_o(valid),
    .addr_ready_i(ready), .strb_o(strb), .buf_sel_o(bsel),
    .writer_inactive_o(inact), .frame_done_o(fdone)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0, done_seen = 0, done_exp = 0;
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] mon_exp;
  logic [15:0]   lfsr = 16'hACE1;
  logic [NBUF-1:0] ben = '1, wen = '1;
  logic [STBW-1:0] stb = 8'hFC;
  bit blk = 1'b0;
  logic [AW-1:0] nxt;

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each accepted address is popped and compared
  always @(negedge clk) begin
    #1;
    if (rst_n && valid && ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected address", addr, '0);
      else begin
        mon_exp = exp_q.pop_front();
        chk(addr == mon_exp, "R3 address sequence", addr, mon_exp);
      end
    end
    if (rst_n && fdone) done_seen++;
  end

  function automatic logic [AW-1:0] ctrl_word(input bit sw, input bit ld, input bit rs);
    return AW'({blk, rs, ld, sw, stb, wen, ben});
  endfunction

  task automatic wr(input int s, input logic [AW-1:0] d);
    @(negedge clk);
    we = 1'b1; sel = SELW'(s); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic push_frame(input logic [AW-1:0] b, input logic [AW-1:0] e,
                            input logic [AW-1:0] ci, input logic [AW-1:0] ri,
                            input int bur, input int maxn, output logic [AW-1:0] nx);
    logic [AW-1:0] cur, row;
    int col;
    cur = b; row = b; col = 0;
    for (int n = 0; n < maxn; n++) begin
      exp_q.push_back(cur);
      if (cur == e) begin done_exp++; break; end
      if (col == bur) begin col = 0; row = row + ri; cur = row; end
      else begin col++; cur = cur + ci; end
    end
    nx = cur;
  endtask

  task automatic drain(input bit rnd);
    forever begin
      @(negedge clk);
      ready = rnd ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #2;
      if (exp_q.size() == 0) break;
    end
    @(posedge clk); #1;
    ready = 1'b0;
  endtask

  task automatic frame(input int k, input int maxn, output logic [AW-1:0] nx);
    push_frame(AW'(32'h1000 * (k + 1)), AW'(32'h1000 * (k + 1) + 32'h204),
               32'h4, 32'h100, 2, maxn, nx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(valid == 1'b0, "R1 valid after reset", AW'(valid), 0);
    chk(bsel == 0, "R1 buffer after reset", AW'(bsel), 0);
    chk(inact == 4'hF, "R1 inactive after reset", AW'(inact), 32'hF);
    chk(strb == 8'hFC, "R1 strobe default", AW'(strb), 32'hFC);
    chk(fdone == 1'b0, "R1 done after reset", AW'(fdone), 0);

    // R2 load with default registers; R3 walk across the default row
    wr(S_CTRL, ctrl_word(0, 1, 0));
    chk(valid && addr == 32'h1800_0000, "R2 load shows default base", addr, 32'h1800_0000);
    push_frame(32'h1800_0000, 32'h19FF_0000, 32'h80, 32'h80, 32'h7E, 130, nxt);
    drain(1'b1);
    chk(addr == 32'h1800_0200 && nxt == addr, "R3 default burst row step", addr, 32'h1800_0200);
    chk(valid == 1'b1, "R4 still offering without ready", AW'(valid), 1);

    // short frames
    for (int k = 0; k < NBUF; k++) begin
      wr(k, AW'(32'h1000 * (k + 1)));
      wr(k + 4, AW'(32'h1000 * (k + 1) + 32'h204));
    end
    wr(8, 32'h4); wr(9, 32'h100); wr(10, 32'h2);
    frame(0, 100, nxt);
    wr(S_CTRL, ctrl_word(0, 1, 0));
    chk(addr == 32'h1000, "R2 load buffer 0 base", addr, 32'h1000);
    repeat (2) @(negedge clk);
    #1;
    chk(addr == 32'h1000 && valid, "R4 address held while not ready", addr, 32'h1000);
    drain(1'b1);
    chk(valid == 1'b0, "R5 idle after end pattern", AW'(valid), 0);
    chk(done_seen == done_exp, "R5 frame done count", AW'(done_seen), AW'(done_exp));

    // R6 chained switch skips disabled buffer 2
    ben = 4'b1011;
    frame(1, 100, nxt);
    frame(3, 100, nxt);
    wr(S_CTRL, ctrl_word(1, 0, 0));
    wr(S_CTRL, ctrl_word(1, 0, 0));
    drain(1'b1);
    chk(bsel == 3, "R6 chained switch skips disabled", AW'(bsel), 3);
    chk(done_seen == done_exp, "R6 frame done count", AW'(done_seen), AW'(done_exp));
    frame(0, 100, nxt);
    wr(S_CTRL, ctrl_word(1, 0, 0));
    drain(1'b1);
    chk(bsel == 0, "R6 wrap to buffer 0", AW'(bsel), 0);
    chk(valid == 1'b0, "R5 idle after wrapped frame", AW'(valid), 0);

    // R8 freeze holds pending switch
    blk = 1'b1;
    wr(S_CTRL, ctrl_word(1, 0, 0));
    repeat (3) @(negedge clk);
    #1;
    chk(bsel == 0 && !valid, "R8 switch frozen", AW'(bsel), 0);
    frame(1, 100, nxt);
    blk = 1'b0;
    wr(S_CTRL, ctrl_word(0, 0, 0));
    drain(1'b1);
    chk(bsel == 1, "R8 switch after unfreeze", AW'(bsel), 1);

    // R9 restart request mid-frame
    frame(1, 3, nxt);
    wr(S_CTRL, ctrl_word(0, 1, 0));
    drain(1'b0);
    chk(addr == 32'h2100, "R3 row step after burst", addr, 32'h2100);
    wr(S_CTRL, ctrl_word(0, 0, 1));
    chk(addr == 32'h2000 && valid, "R9 restart reloads base", addr, 32'h2000);
    frame(1, 100, nxt);
    drain(1'b1);
    chk(done_seen == done_exp, "R9 frame done count", AW'(done_seen), AW'(done_exp));

    // R10 writer enable gating
    wen = 4'b1101;
    wr(S_CTRL, ctrl_word(0, 1, 0));
    chk(!valid && inact == 4'hF, "R10 writer disabled", AW'(inact), 32'hF);
    wen = 4'hF;
    wr(S_CTRL, ctrl_word(0, 0, 0));
    chk(valid && addr == 32'h2000, "R10 writer enabled offers base", addr, 32'h2000);
    chk(inact == 4'b1101, "R10 selected writer active", AW'(inact), 32'hD);
    frame(1, 100, nxt);
    drain(1'b1);
    chk(inact == 4'hF, "R10 all inactive when idle", AW'(inact), 32'hF);

    // R7 no buffer enabled
    ben = 4'h0;
    frame(1, 100, nxt);
    wr(S_CTRL, ctrl_word(1, 0, 0));
    drain(1'b1);
    chk(bsel == 1, "R7 selection held", AW'(bsel), 1);
    chk(done_seen == done_exp, "R7 frame done count", AW'(done_seen), AW'(done_exp));

    // R11 strobe field
    stb = 8'h5A;
    wr(S_CTRL, ctrl_word(0, 0, 0));
    chk(strb == 8'h5A, "R11 strobe follows control", AW'(strb), 32'h5A);
    chk(exp_q.size() == 0, "R3 all expected addresses seen", AW'(exp_q.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule